// File: doc/BRIEF.md
# Inter-Processor Doorbell Unit

This block gives every core in a cluster two doorbells. The "other" doorbell is rung by any core on behalf of a set of target cores. The "self" doorbell is rung by a core on itself. Each core reaches the block through a shared 32-bit register bus. Every access carries the identity of the requesting core, so writes to the trigger, acknowledge and gate registers act on the requesting core's doorbells without the software naming a core.

Each doorbell has a pending bit and a mask bit. A core's interrupt line is high while any of its doorbells is pending and not masked. When the core reads the shared event register, the block reports the highest-priority eligible doorbell as a doorbell-type event. The report also masks that doorbell, so the same event is not reported twice. Software then acknowledges the doorbell and removes the mask. When no doorbell of the reading core is eligible, the read returns the event word offered by the external-source path and consumes it.

Top module: `ipi_mailbox`

## Requirements
- R1: After reset every doorbell is masked and not pending. Every `irq_o` bit is low. An event read returns 0 while `ext_valid_i` is low.
- R2: A write to offset 0x2008 with bit 0 set makes the "other" doorbell pending on each core t whose bit 1+t is set. The doorbells of cores whose bit is clear do not change.
- R3: A write to offset 0x2008 with bit 31 set makes the "self" doorbell of the writing core pending, and of no other core.
- R4: A write to offset 0x200C clears the writing core's pending "other" doorbell if bit 0 is set and its pending "self" doorbell if bit 31 is set. Other cores are not affected.
- R5: A write to offset 0x2024 masks, and a write to 0x2028 unmasks, the writing core's "other" doorbell (bit 0) and "self" doorbell (bit 31). Bits written as 0 leave their mask unchanged.
- R6: `irq_o[c]` is high exactly while core c has a doorbell that is pending and not masked.
- R7: A read of offset 0x2004 by a core reports an eligible doorbell in the same cycle. The word holds 0 in bits 31:24 and type 4 in bits 23:16. Bits 15:0 hold 1 for "other" or 2 for "self". "Other" is reported before "self".
- R8: Reporting a doorbell masks that doorbell for the reading core. Its pending bit is kept, so a later unmask raises the interrupt again.
- R9: A doorbell event takes priority over the external word. If the reading core has no eligible doorbell and `ext_valid_i` is high, `rdata_o` equals `ext_evt_i` and `ext_take_o` pulses. Otherwise `ext_take_o` stays low, and the read returns 0 when nothing is eligible.
- R10: An access whose `core_id_i` is not below `N_CORES` has no effect on any doorbell and returns 0. Reads of any offset other than 0x2004 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| core_id_i | input | 5 | Identity of the requesting core |
| rdata_o | output | 32 | Read data, valid in the cycle of the read |
| ext_valid_i | input | 1 | External-source event word available |
| ext_evt_i | input | 32 | External-source event word |
| ext_take_o | output | 1 | External word consumed by this read |
| irq_o | output | N_CORES | Per-core doorbell interrupt |

## Verification
The bench targets three corner cases.

- When both doorbells of a core are eligible and the core reads twice, the reads must return "other" and then "self". A design with the wrong priority returns them in the other order. A design that does not mask on report returns the same event twice.
- With an external word offered while a doorbell is eligible, a design that gives the external path priority consumes the word and hides the doorbell.
- The bench sends to sparse target masks and issues accesses from out-of-range core identities. A design with off-by-one target decoding, or that does not gate on the core identity, rings or clears the wrong core's doorbell. The per-cycle interrupt comparison catches that at once.

// File: rtl/ipi_mbx_pkg.sv
package ipi_mbx_pkg;
  localparam int CID_W  = 5;
  localparam int ADDR_W = 16;

  localparam logic [ADDR_W-1:0] EVT_OFS  = 16'h2004;
  localparam logic [ADDR_W-1:0] SEND_OFS = 16'h2008;
  localparam logic [ADDR_W-1:0] ACK_OFS  = 16'h200C;
  localparam logic [ADDR_W-1:0] MSET_OFS = 16'h2024;
  localparam logic [ADDR_W-1:0] MCLR_OFS = 16'h2028;

  localparam int OTHER_BIT = 0;
  localparam int SELF_BIT  = 31;

  localparam logic [7:0]  TYPE_DBELL = 8'd4;
  localparam logic [15:0] SUB_OTHER  = 16'd1;
  localparam logic [15:0] SUB_SELF   = 16'd2;

  typedef struct packed {
    logic raise;
    logic ack;
    logic mset;
    logic mclr;
  } slot_ctl_t;

  function automatic logic [31:0] dbell_word(input logic [15:0] sub);
    return {8'h00, TYPE_DBELL, sub};
  endfunction
endpackage

// File: rtl/ipi_dbell.sv
module ipi_dbell
  import ipi_mbx_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  slot_ctl_t ctl_i,
  output logic      elig_o
);
  logic pend_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      mask_q <= 1'b1;
    end else begin
      if (ctl_i.raise)     pend_q <= 1'b1;
      else if (ctl_i.ack)  pend_q <= 1'b0;
      if (ctl_i.mset)      mask_q <= 1'b1;
      else if (ctl_i.mclr) mask_q <= 1'b0;
    end
  end

  assign elig_o = pend_q & ~mask_q;
endmodule

// File: rtl/ipi_evt_sel.sv
module ipi_evt_sel
  import ipi_mbx_pkg::*;
(
  input  logic        rd_i,
  input  logic        other_i,
  input  logic        self_i,
  input  logic        ext_valid_i,
  input  logic [31:0] ext_evt_i,
  output logic [31:0] rdata_o,
  output logic        take_o,
  output logic        pick_other_o,
  output logic        pick_self_o
);
  always_comb begin
    rdata_o      = '0;
    take_o       = 1'b0;
    pick_other_o = 1'b0;
    pick_self_o  = 1'b0;
    if (rd_i) begin
      if (other_i) begin
        pick_other_o = 1'b1;
        rdata_o      = dbell_word(SUB_OTHER);
      end else if (self_i) begin
        pick_self_o = 1'b1;
        rdata_o     = dbell_word(SUB_SELF);
      end else if (ext_valid_i) begin
        take_o  = 1'b1;
        rdata_o = ext_evt_i;
      end
    end
  end
endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox
  import ipi_mbx_pkg::*;
#(
  parameter int N_CORES = 4  // at most 30: targets sit in wdata bits 30:1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [15:0]        addr_i,
  input  logic [31:0]        wdata_i,
  input  logic [4:0]         core_id_i,
  output logic [31:0]        rdata_o,
  input  logic               ext_valid_i,
  input  logic [31:0]        ext_evt_i,
  output logic               ext_take_o,
  output logic [N_CORES-1:0] irq_o
);
  localparam int unsigned NC = N_CORES;

  logic id_ok, wr, rd_evt;
  logic wr_send, wr_ack, wr_mset, wr_mclr;
  logic [N_CORES-1:0] hit, elig_oth, elig_slf;
  logic sel_oth, sel_slf, pick_oth, pick_slf;
  logic unused_wdata;

  assign id_ok   = 32'(core_id_i) < NC;
  assign wr      = req_i & we_i & id_ok;
  assign rd_evt  = req_i & ~we_i & id_ok & (addr_i == EVT_OFS);
  assign wr_send = wr & (addr_i == SEND_OFS);
  assign wr_ack  = wr & (addr_i == ACK_OFS);
  assign wr_mset = wr & (addr_i == MSET_OFS);
  assign wr_mclr = wr & (addr_i == MCLR_OFS);
  assign unused_wdata = ^wdata_i;

  for (genvar c = 0; c < N_CORES; c++) begin : g_core
    slot_ctl_t ctl_oth, ctl_slf;

    assign hit[c] = (core_id_i == CID_W'(c));

    assign ctl_oth.raise = wr_send & wdata_i[OTHER_BIT] & wdata_i[1+c];
    assign ctl_oth.ack   = wr_ack  & wdata_i[OTHER_BIT] & hit[c];
    assign ctl_oth.mset  = (wr_mset & wdata_i[OTHER_BIT] & hit[c]) | (pick_oth & hit[c]);
    assign ctl_oth.mclr  = wr_mclr & wdata_i[OTHER_BIT] & hit[c];

    assign ctl_slf.raise = wr_send & wdata_i[SELF_BIT] & hit[c];
    assign ctl_slf.ack   = wr_ack  & wdata_i[SELF_BIT] & hit[c];
    assign ctl_slf.mset  = (wr_mset & wdata_i[SELF_BIT] & hit[c]) | (pick_slf & hit[c]);
    assign ctl_slf.mclr  = wr_mclr & wdata_i[SELF_BIT] & hit[c];

    ipi_dbell u_oth (.clk_i(clk_i), .rst_ni(rst_ni), .ctl_i(ctl_oth), .elig_o(elig_oth[c]));
    ipi_dbell u_slf (.clk_i(clk_i), .rst_ni(rst_ni), .ctl_i(ctl_slf), .elig_o(elig_slf[c]));

    assign irq_o[c] = elig_oth[c] | elig_slf[c];
  end

  always_comb begin
    sel_oth = 1'b0;
    sel_slf = 1'b0;
    for (int c = 0; c < N_CORES; c++) begin
      sel_oth = sel_oth | (hit[c] & elig_oth[c]);
      sel_slf = sel_slf | (hit[c] & elig_slf[c]);
    end
  end

  ipi_evt_sel u_sel (
    .rd_i        (rd_evt),
    .other_i     (sel_oth),
    .self_i      (sel_slf),
    .ext_valid_i (ext_valid_i),
    .ext_evt_i   (ext_evt_i),
    .rdata_o     (rdata_o),
    .take_o      (ext_take_o),
    .pick_other_o(pick_oth),
    .pick_self_o (pick_slf)
  );
endmodule

// File: rtl/ipi_mailbox_chk.sv
module ipi_mailbox_chk
  import ipi_mbx_pkg::*;
#(
  parameter int N_CORES = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_i,
  input logic               we_i,
  input logic [15:0]        addr_i,
  input logic [31:0]        wdata_i,
  input logic [4:0]         core_id_i,
  input logic [31:0]        rdata_o,
  input logic               ext_valid_i,
  input logic [31:0]        ext_evt_i,
  input logic               ext_take_o,
  input logic [N_CORES-1:0] irq_o
);
  localparam int unsigned NC = N_CORES;

  logic id_ok;
  assign id_ok = 32'(core_id_i) < NC;

  // R4: acknowledging both kinds silences the writer's interrupt
  p_ack_both_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && id_ok && addr_i == ACK_OFS && wdata_i[0] && wdata_i[31])
    |=> !irq_o[$past(core_id_i)]);

  // R5: masking both kinds silences the writer's interrupt
  p_mask_both_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && id_ok && addr_i == MSET_OFS && wdata_i[0] && wdata_i[31])
    |=> !irq_o[$past(core_id_i)]);

  // R7: doorbell words carry a legal sub-code and a zero top byte
  p_evt_fmt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == EVT_OFS && !ext_take_o && rdata_o[23:16] == TYPE_DBELL)
    |-> (rdata_o[31:24] == 8'h00 && (rdata_o[15:0] == SUB_OTHER || rdata_o[15:0] == SUB_SELF)));

  // R9: the external word is consumed only by a valid event read and passed unchanged
  p_ext_take_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_take_o |-> (req_i && !we_i && id_ok && addr_i == EVT_OFS && ext_valid_i && rdata_o == ext_evt_i));

  // R6: an interrupt can only rise after a write
  for (genvar c = 0; c < N_CORES; c++) begin : g_irq
    p_irq_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_o[c]) |-> $past(req_i && we_i));
  end
endmodule

bind ipi_mailbox ipi_mailbox_chk #(.N_CORES(N_CORES)) u_chk (.*);

// File: tb/ipi_mailbox_tb.sv
`timescale 1ns/1ps
module ipi_mailbox_tb;
  localparam int NC = 4;
  localparam logic [15:0] A_EVT = 16'h2004, A_SEND = 16'h2008, A_ACK = 16'h200C,
                          A_MSET = 16'h2024, A_MCLR = 16'h2028, A_OTHER = 16'h2000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, ext_valid = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0, ext_evt = '0;
  logic [4:0] core_id = '0;
  logic [31:0] rdata;
  logic ext_take;
  logic [NC-1:0] irq;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  bit po[NC], ps[NC], mo[NC], ms[NC];

  always #10 clk = ~clk;

  ipi_mailbox #(.N_CORES(NC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .core_id_i(core_id), .rdata_o(rdata),
    .ext_valid_i(ext_valid), .ext_evt_i(ext_evt), .ext_take_o(ext_take), .irq_o(irq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] model_irq();
    logic [31:0] v = '0;
    for (int c = 0; c < NC; c++) v[c] = (po[c] & ~mo[c]) | (ps[c] & ~ms[c]);
    return v;
  endfunction

  // one bus cycle: checks irq from the previous edge, then this cycle's read result
  task automatic step(input int c, input bit w, input logic [15:0] a, input logic [31:0] d,
                      input bit ev, input logic [31:0] ew, input string tag);
    logic [31:0] exp_rd;
    bit exp_take, ok;
    @(negedge clk);
    chk(32'(irq), model_irq(), {tag, " irq R6"});
    req = 1'b1; we = w; addr = a; wdata = d; core_id = c[4:0];
    ext_valid = ev; ext_evt = ew;
    #1;
    exp_rd = '0; exp_take = 0; ok = (c < NC);
    if (ok && !w && a == A_EVT) begin
      if (po[c] && !mo[c]) begin exp_rd = 32'h0004_0001; mo[c] = 1; end
      else if (ps[c] && !ms[c]) begin exp_rd = 32'h0004_0002; ms[c] = 1; end
      else if (ev) begin exp_rd = ew; exp_take = 1; end
    end
    chk(rdata, exp_rd, {tag, " rdata R7/R9/R10"});
    chk(32'(ext_take), 32'(exp_take), {tag, " take R9"});
    if (ok && w) begin
      case (a)
        A_SEND: begin
          if (d[0]) for (int t = 0; t < NC; t++) if (d[1+t]) po[t] = 1;
          if (d[31]) ps[c] = 1;
        end
        A_ACK:  begin if (d[0]) po[c] = 0; if (d[31]) ps[c] = 0; end
        A_MSET: begin if (d[0]) mo[c] = 1; if (d[31]) ms[c] = 1; end
        A_MCLR: begin if (d[0]) mo[c] = 0; if (d[31]) ms[c] = 0; end
        default: ;
      endcase
    end
    @(posedge clk);
  endtask

  task automatic rd(input int c, input bit ev, input logic [31:0] ew, input string tag);
    step(c, 0, A_EVT, 32'h0, ev, ew, tag);
  endtask

  task automatic wr(input int c, input logic [15:0] a, input logic [31:0] d, input string tag);
    step(c, 1, a, d, 0, 32'h0, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(64'd200000 * 20);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int c = 0; c < NC; c++) begin po[c] = 0; ps[c] = 0; mo[c] = 1; ms[c] = 1; end
    req = 1'b1; we = 1'b0; addr = A_EVT; core_id = '0;
    #25;
    chk(32'(irq), 32'h0, "R1 irq in reset");
    chk(rdata, 32'h0, "R1 rdata in reset");
    req = 1'b0;
    @(negedge clk); rst_n = 1'b1;

    // R1: nothing pending, all masked
    for (int c = 0; c < NC; c++) rd(c, 0, 32'h0, "R1 empty read");
    // R2/R3 while masked: irq stays low
    wr(0, A_SEND, 32'h8000_001F, "R1 send masked");
    wr(2, A_SEND, 32'h8000_0000, "R3 self core2");
    // R5: unmask core0 and core1
    wr(0, A_MCLR, 32'h8000_0001, "R5 unmask c0");
    wr(1, A_MCLR, 32'h0000_0001, "R5 unmask c1 other");
    // R7 order, R8 auto-mask
    rd(0, 0, 32'h0, "R7 other first");
    rd(0, 0, 32'h0, "R8 then self");
    rd(0, 0, 32'h0, "R8 both masked");
    // R9: doorbell beats the external word
    rd(1, 1, 32'h0001_0007, "R9 dbell priority");
    wr(1, A_MCLR, 32'h0000_0001, "R8 unmask keeps pending");
    // R4: ack only the writer
    wr(1, A_ACK, 32'h8000_0001, "R4 ack c1");
    wr(0, A_MCLR, 32'h8000_0001, "R4 c0 still pending");
    wr(0, A_ACK, 32'h0000_0001, "R4 ack c0 other");
    wr(0, A_ACK, 32'h8000_0000, "R4 ack c0 self");
    // R2: sparse targets
    wr(3, A_SEND, 32'h0000_0015, "R2 targets c1 c3");
    wr(3, A_MCLR, 32'h0000_0001, "R2 unmask c3");
    wr(2, A_MCLR, 32'h0000_0001, "R2 c2 not targeted");
    wr(2, A_MCLR, 32'h8000_0000, "R3 c2 self unmask");
    // R10: out-of-range requester
    wr(5, A_SEND, 32'hFFFF_FFFF, "R10 bad id send");
    wr(4, A_MCLR, 32'hFFFF_FFFF, "R10 bad id mclr");
    rd(6, 1, 32'h0001_0009, "R10 bad id read");
    step(0, 0, A_OTHER, 32'h0, 1, 32'h0001_0003, "R10 other offset");
    // R9: nothing eligible, external passes through
    rd(0, 1, 32'h0001_0042, "R9 ext pass");
    rd(1, 0, 32'h0, "R9 nothing");

    for (int i = 0; i < 800; i++) begin
      int c, k;
      logic [15:0] a;
      logic [31:0] d;
      c = $urandom_range(0, NC + 1);
      k = $urandom_range(0, 6);
      d = $urandom;
      case (k)
        0: a = A_EVT;  1: a = A_SEND; 2: a = A_ACK; 3: a = A_MSET;
        4: a = A_MCLR; 5: a = A_EVT;  default: a = A_OTHER;
      endcase
      step(c, (k >= 1 && k <= 4), a, d, bit'($urandom_range(0, 1)), $urandom, "rand");
    end
    step(0, 0, A_OTHER, 32'h0, 0, 32'h0, "final");
    finish_run();
  end
endmodule